// File: doc/BRIEF.md
# Interrupt Controller Register Slave

This block is the software-visible register file of a small nested vectored interrupt controller. It holds, for a parameterized number of interrupt lines, an enable bit, a pending bit and a priority field. It also holds a control register and a base address for the exception vector table. A processor reaches the block through a simple bus slave port. A separate arbiter reads the enable, pending and priority vectors straight from the output ports. The arbiter pulses per-line set and clear inputs when a line fires or when its handler is entered.

Access follows privilege. Privileged code may read and write everything. Unprivileged code may only raise pending bits, through the pending-set offset, and only while the control register allows it. Every other unprivileged access, read or write, returns a bus error and changes nothing. Each access is answered one cycle after its strobe, with read data and an error flag.

The offset map is as follows. Enable set is at 0x000 and enable clear at 0x080. Pending set is at 0x100 and pending clear at 0x180. Each of these spans as many 32-bit words as the line count needs. The priority bytes start at 0x200, one byte per line. The control register is at 0x300 and the vector base at 0x304.

Top module: `irq_ctrl_regs`

## Requirements
- R1: After reset, every enable bit, pending bit, priority field, the control register and the vector base read zero, and the bus response flags no error.
- R2: A write of ones at enable-set word k (offset 0x000+4k) sets the matching enable bits of lines 32k..32k+31, and a write at enable-clear (0x080+4k) clears them; both offsets read back the current enable word; zero bits in the write data leave bits unchanged.
- R3: Pending bits follow the same scheme, with set words at 0x100+4k and clear words at 0x180+4k; both offsets read the current pending word.
- R4: Line i has its priority in byte i from offset 0x200 (little-endian, so byte i sits in data bits 8*(i%4)+7..8*(i%4) of word 0x200+4*(i/4)); only the upper 4 bits of each byte are stored, the low 4 read as zero, and bytes for lines that do not exist read zero.
- R5: Bus size 0 is a byte, 1 a halfword and 2 a word; a byte uses lane addr[1:0], a halfword uses lanes 0-1 or 2-3 by addr[1], a word uses all four lanes, and unselected lanes are left untouched by writes.
- R6: The vector base at 0x304 stores only bits 29..7; bits 31..30 and 6..0 always read zero, so the held value is a 128-byte aligned address no greater than 0x3FFFFF80.
- R7: Bit 0 of the control register at 0x300 lets unprivileged writes to the pending-set offsets take effect without error.
- R8: Any other unprivileged access sets the error flag in the response, returns zero data and changes no register.
- R9: A privileged access to an offset that holds no register reads zero, ignores write data and flags no error.
- R10: The arbiter's per-line set and clear pulses act on the pending bits in the cycle they are given, together with bus writes; when a set and a clear reach the same bit in one cycle, the bit ends up set.
- R11: The response (read data, error flag) appears in the cycle after the access strobe; with no strobe, the read data is zero and no error is flagged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | Access strobe, one cycle per access |
| bus_write | input | 1 | 1 for write, 0 for read |
| bus_priv | input | 1 | 1 when the access is privileged |
| bus_addr | input | 10 | Byte offset inside the block |
| bus_size | input | 2 | 0 byte, 1 halfword, 2 word |
| bus_wdata | input | 32 | Write data, lane aligned, little-endian |
| bus_rdata | output | 32 | Read data, valid the cycle after the strobe |
| bus_err | output | 1 | Error response, valid the cycle after the strobe |
| arb_set_pend | input | NUM_IRQ | Per-line pending set pulses from the arbiter |
| arb_clr_pend | input | NUM_IRQ | Per-line pending clear pulses from the arbiter |
| irq_enable | output | NUM_IRQ | Enable bit of each line |
| irq_pending | output | NUM_IRQ | Pending bit of each line |
| irq_prio | output | NUM_IRQ*PRIO_BITS | Stored priority of each line, line i at bits i*PRIO_BITS upward |
| vec_base | output | 32 | Vector table base address |

## Verification
The assertions assume that bus_valid is a single-cycle strobe and that the address, size and data inputs are steady while it is high. They also assume the enable vector changes only through accepted bus writes, because no arbiter input acts on it. The bench drives every access from a task that raises the strobe for exactly one cycle. It changes the inputs only at falling edges and returns them to idle before the next access. The arbiter pulses are likewise given one cycle wide, and the bench drives one case where they fall in the same cycle as a bus write.

// File: rtl/irq_regs_pkg.sv
package irq_regs_pkg;

  // Upper address bits [9:7] pick one of eight 128-byte windows.
  typedef enum logic [2:0] {
    RG_EN_SET  = 3'd0,
    RG_EN_CLR  = 3'd1,
    RG_PD_SET  = 3'd2,
    RG_PD_CLR  = 3'd3,
    RG_PRIO_LO = 3'd4,
    RG_PRIO_HI = 3'd5,
    RG_SYS     = 3'd6,
    RG_NONE    = 3'd7
  } region_e;

  localparam int unsigned OFS_W = 10;

  // Byte lanes touched by an access of the given size at the given low address bits.
  function automatic logic [3:0] lane_mask(input logic [1:0] size, input logic [1:0] lo);
    case (size)
      2'd0:    lane_mask = 4'b0001 << lo;
      2'd1:    lane_mask = lo[1] ? 4'b1100 : 4'b0011;
      default: lane_mask = 4'b1111;
    endcase
  endfunction

  // Expand a lane mask to a 32-bit bit mask.
  function automatic logic [31:0] lane_bits(input logic [3:0] m);
    for (int b = 0; b < 4; b++) lane_bits[8*b +: 8] = {8{m[b]}};
  endfunction

endpackage

// File: rtl/irq_regs_decode.sv
module irq_regs_decode
  import irq_regs_pkg::*;
(
  input  logic             acc_valid,
  input  logic             acc_write,
  input  logic             acc_priv,
  input  logic [OFS_W-1:0] acc_addr,
  input  logic [1:0]       acc_size,
  input  logic             user_pend_ok,
  output region_e          region,
  output logic [3:0]       lanes,
  output logic             accept,
  output logic             reject
);

  logic user_allowed;

  assign region       = region_e'(acc_addr[9:7]);
  assign lanes        = lane_mask(acc_size, acc_addr[1:0]);
  assign user_allowed = acc_write && (region == RG_PD_SET) && user_pend_ok;
  assign reject       = acc_valid && !acc_priv && !user_allowed;
  assign accept       = acc_valid && !reject;

endmodule

// File: rtl/irq_regs_bitvec.sv
module irq_regs_bitvec #(
  parameter int unsigned NBITS = 48,
  localparam int unsigned WORDS = (NBITS + 31) / 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_set,
  input  logic             wr_clr,
  input  logic [5:0]       word_sel,
  input  logic [31:0]      wr_bits,
  input  logic [NBITS-1:0] hw_set,
  input  logic [NBITS-1:0] hw_clr,
  output logic [NBITS-1:0] q,
  output logic [31:0]      rd_word
);

  logic [NBITS-1:0]    set_all, clr_all, q_r;
  logic [WORDS*32-1:0] padded;
  logic                unused_ok;

  for (genvar i = 0; i < NBITS; i++) begin : g_bit
    localparam int unsigned W = i / 32;
    localparam int unsigned B = i % 32;
    logic hit;
    assign hit        = (word_sel == 6'(W));
    assign set_all[i] = hw_set[i] | (wr_set & hit & wr_bits[B]);
    assign clr_all[i] = hw_clr[i] | (wr_clr & hit & wr_bits[B]);
  end

  // Set has priority over clear on the same bit.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_r <= '0;
    else        q_r <= (q_r & ~clr_all) | set_all;
  end

  always_comb begin
    padded = '0;
    padded[NBITS-1:0] = q_r;
    rd_word = '0;
    if (int'(word_sel) < WORDS) rd_word = padded[int'(word_sel)*32 +: 32];
  end

  assign q         = q_r;
  assign unused_ok = ^wr_bits;

  AST_SET_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    (|set_all) |=> ((q_r & $past(set_all)) == $past(set_all))); // R10

  AST_CLR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    (|(clr_all & ~set_all)) |=> ((q_r & $past(clr_all & ~set_all)) == '0)); // R3

  AST_QUIET_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!(|set_all) && !(|clr_all)) |=> $stable(q_r)); // R2

endmodule

// File: rtl/irq_regs_prio.sv
module irq_regs_prio #(
  parameter int unsigned NLINES    = 48,
  parameter int unsigned PRIO_BITS = 4,
  localparam int unsigned LOW      = 8 - PRIO_BITS
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        wr_en,
  input  logic [5:0]                  word_sel,
  input  logic [3:0]                  lanes,
  input  logic [31:0]                 wdata,
  output logic [NLINES*PRIO_BITS-1:0] prio_flat,
  output logic [31:0]                 rd_word
);

  logic [PRIO_BITS-1:0] pr [NLINES];
  logic                 unused_ok;

  for (genvar i = 0; i < NLINES; i++) begin : g_line
    localparam int unsigned L = i % 4;
    localparam int unsigned W = i / 4;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        pr[i] <= '0;
      else if (wr_en && (word_sel == 6'(W)) && lanes[L])
        pr[i] <= wdata[8*L+LOW +: PRIO_BITS];
    end
    assign prio_flat[i*PRIO_BITS +: PRIO_BITS] = pr[i];
  end

  always_comb begin
    rd_word = '0;
    for (int l = 0; l < 4; l++) begin
      if (int'(word_sel) * 4 + l < NLINES)
        rd_word[8*l+LOW +: PRIO_BITS] = pr[int'(word_sel) * 4 + l];
    end
  end

  assign unused_ok = ^wdata;

  AST_PRIO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(prio_flat)); // R8

endmodule

// File: rtl/irq_ctrl_regs.sv
module irq_ctrl_regs
  import irq_regs_pkg::*;
#(
  parameter int unsigned NUM_IRQ   = 48,
  parameter int unsigned PRIO_BITS = 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         bus_valid,
  input  logic                         bus_write,
  input  logic                         bus_priv,
  input  logic [9:0]                   bus_addr,
  input  logic [1:0]                   bus_size,
  input  logic [31:0]                  bus_wdata,
  output logic [31:0]                  bus_rdata,
  output logic                         bus_err,
  input  logic [NUM_IRQ-1:0]           arb_set_pend,
  input  logic [NUM_IRQ-1:0]           arb_clr_pend,
  output logic [NUM_IRQ-1:0]           irq_enable,
  output logic [NUM_IRQ-1:0]           irq_pending,
  output logic [NUM_IRQ*PRIO_BITS-1:0] irq_prio,
  output logic [31:0]                  vec_base
);

  region_e     region;
  logic [3:0]  lanes;
  logic        acc_accept, acc_reject, wen;
  logic [31:0] lane_msk, wr_bits;
  logic [5:0]  bit_word, prio_word;
  logic [4:0]  sys_sel;
  logic [31:0] en_rd, pd_rd, pr_rd, rd_mux;
  logic        ctrl_q;
  logic [22:0] vbase_q;
  logic [31:0] vbase_nxt;
  logic [31:0] rdata_q;
  logic        err_q;
  logic        unused_ok;

  irq_regs_decode u_decode (
    .acc_valid    (bus_valid),
    .acc_write    (bus_write),
    .acc_priv     (bus_priv),
    .acc_addr     (bus_addr),
    .acc_size     (bus_size),
    .user_pend_ok (ctrl_q),
    .region       (region),
    .lanes        (lanes),
    .accept       (acc_accept),
    .reject       (acc_reject)
  );

  assign wen       = acc_accept && bus_write;
  assign lane_msk  = lane_bits(lanes);
  assign wr_bits   = bus_wdata & lane_msk;
  assign bit_word  = {1'b0, bus_addr[6:2]};
  assign prio_word = bus_addr[7:2];
  assign sys_sel   = bus_addr[6:2];

  irq_regs_bitvec #(.NBITS(NUM_IRQ)) u_enable (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_set   (wen && region == RG_EN_SET),
    .wr_clr   (wen && region == RG_EN_CLR),
    .word_sel (bit_word),
    .wr_bits  (wr_bits),
    .hw_set   ('0),
    .hw_clr   ('0),
    .q        (irq_enable),
    .rd_word  (en_rd)
  );

  irq_regs_bitvec #(.NBITS(NUM_IRQ)) u_pending (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_set   (wen && region == RG_PD_SET),
    .wr_clr   (wen && region == RG_PD_CLR),
    .word_sel (bit_word),
    .wr_bits  (wr_bits),
    .hw_set   (arb_set_pend),
    .hw_clr   (arb_clr_pend),
    .q        (irq_pending),
    .rd_word  (pd_rd)
  );

  irq_regs_prio #(.NLINES(NUM_IRQ), .PRIO_BITS(PRIO_BITS)) u_prio (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wen && (region == RG_PRIO_LO || region == RG_PRIO_HI)),
    .word_sel  (prio_word),
    .lanes     (lanes),
    .wdata     (bus_wdata),
    .prio_flat (irq_prio),
    .rd_word   (pr_rd)
  );

  // Vector base keeps only bits 29..7; lane merge on the full word.
  assign vec_base  = {2'b00, vbase_q, 7'b0};
  assign vbase_nxt = (vec_base & ~lane_msk) | wr_bits;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q  <= 1'b0;
      vbase_q <= '0;
    end else if (wen && region == RG_SYS) begin
      if (sys_sel == 5'd0 && lanes[0]) ctrl_q  <= bus_wdata[0];
      if (sys_sel == 5'd1)             vbase_q <= vbase_nxt[29:7];
    end
  end

  always_comb begin
    case (region)
      RG_EN_SET, RG_EN_CLR:   rd_mux = en_rd;
      RG_PD_SET, RG_PD_CLR:   rd_mux = pd_rd;
      RG_PRIO_LO, RG_PRIO_HI: rd_mux = pr_rd;
      RG_SYS: begin
        if (sys_sel == 5'd0)      rd_mux = {31'b0, ctrl_q};
        else if (sys_sel == 5'd1) rd_mux = vec_base;
        else                      rd_mux = '0;
      end
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
      err_q   <= 1'b0;
    end else begin
      err_q   <= acc_reject;
      rdata_q <= (acc_accept && !bus_write) ? rd_mux : '0;
    end
  end

  assign bus_rdata = rdata_q;
  assign bus_err   = err_q;
  assign unused_ok = ^{vbase_nxt[31:30], vbase_nxt[6:0]};

  AST_REJECT_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    acc_reject |=> (bus_err && bus_rdata == '0)); // R8

  AST_REJECT_NO_ENABLE_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
    acc_reject |=> $stable(irq_enable)); // R8

  AST_USER_PEND_OK: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && !bus_priv && bus_write && region == RG_PD_SET && ctrl_q) |=> !bus_err); // R7

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_valid |=> (!bus_err && bus_rdata == '0)); // R11

  AST_VBASE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_valid && bus_write && bus_priv) |=> $stable(vec_base)); // R6

endmodule

// File: tb/test_irq_ctrl_regs.sv
module test_irq_ctrl_regs;

  localparam int unsigned N  = 48;
  localparam int unsigned PB = 4;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              bus_valid = 1'b0, bus_write = 1'b0, bus_priv = 1'b0;
  logic [9:0]        bus_addr = '0;
  logic [1:0]        bus_size = '0;
  logic [31:0]       bus_wdata = '0;
  logic [31:0]       bus_rdata;
  logic              bus_err;
  logic [N-1:0]      arb_set_pend = '0, arb_clr_pend = '0;
  logic [N-1:0]      irq_enable, irq_pending;
  logic [N*PB-1:0]   irq_prio;
  logic [31:0]       vec_base;

  int errors = 0;
  int checks = 0;

  always #2 clk = ~clk;

  irq_ctrl_regs #(.NUM_IRQ(N), .PRIO_BITS(PB)) i_irq_ctrl_regs (
    .clk, .rst_n, .bus_valid, .bus_write, .bus_priv, .bus_addr, .bus_size,
    .bus_wdata, .bus_rdata, .bus_err, .arb_set_pend, .arb_clr_pend,
    .irq_enable, .irq_pending, .irq_prio, .vec_base
  );

  typedef struct packed {
    logic        wr;
    logic        priv;
    logic [1:0]  size;
    logic [9:0]  addr;
    logic [31:0] wdata;
    logic        err;
    logic [31:0] rdata;
  } vec_t;

  localparam int NV = 42;
  localparam vec_t VT [NV] = '{
    '{1'b0, 1'b1, 2'd2, 10'h000, 32'h0,        1'b0, 32'h0},        // R1 reset enable
    '{1'b1, 1'b1, 2'd2, 10'h000, 32'h000000A5, 1'b0, 32'h0},        // R2 set
    '{1'b0, 1'b1, 2'd2, 10'h080, 32'h0,        1'b0, 32'h000000A5}, // R2 read via clear
    '{1'b1, 1'b1, 2'd0, 10'h080, 32'h00000021, 1'b0, 32'h0},        // R5 byte clear
    '{1'b0, 1'b1, 2'd2, 10'h000, 32'h0,        1'b0, 32'h00000084}, // R2
    '{1'b1, 1'b1, 2'd1, 10'h006, 32'hFFFF0000, 1'b0, 32'h0},        // R5 upper half, no lines
    '{1'b0, 1'b1, 2'd2, 10'h004, 32'h0,        1'b0, 32'h0},        // R5
    '{1'b1, 1'b1, 2'd1, 10'h004, 32'h00008001, 1'b0, 32'h0},        // R5 lower half
    '{1'b0, 1'b1, 2'd2, 10'h004, 32'h0,        1'b0, 32'h00008001}, // R5
    '{1'b1, 1'b1, 2'd2, 10'h200, 32'h12345678, 1'b0, 32'h0},        // R4
    '{1'b0, 1'b1, 2'd2, 10'h200, 32'h0,        1'b0, 32'h10305070}, // R4 low nibbles zero
    '{1'b1, 1'b1, 2'd0, 10'h202, 32'h00FF0000, 1'b0, 32'h0},        // R5 byte lane 2
    '{1'b0, 1'b1, 2'd2, 10'h200, 32'h0,        1'b0, 32'h10F05070}, // R4
    '{1'b1, 1'b1, 2'd2, 10'h22C, 32'hFFFFFFFF, 1'b0, 32'h0},        // R4 last lines
    '{1'b0, 1'b1, 2'd2, 10'h22C, 32'h0,        1'b0, 32'hF0F0F0F0}, // R4
    '{1'b1, 1'b1, 2'd2, 10'h230, 32'hFFFFFFFF, 1'b0, 32'h0},        // R9 beyond last line
    '{1'b0, 1'b1, 2'd2, 10'h230, 32'h0,        1'b0, 32'h0},        // R9
    '{1'b1, 1'b1, 2'd2, 10'h304, 32'hFFFFFFFF, 1'b0, 32'h0},        // R6
    '{1'b0, 1'b1, 2'd2, 10'h304, 32'h0,        1'b0, 32'h3FFFFF80}, // R6
    '{1'b1, 1'b1, 2'd0, 10'h304, 32'h00000045, 1'b0, 32'h0},        // R6 byte merge
    '{1'b0, 1'b1, 2'd2, 10'h304, 32'h0,        1'b0, 32'h3FFFFF00}, // R6
    '{1'b1, 1'b1, 2'd2, 10'h3F0, 32'hFFFFFFFF, 1'b0, 32'h0},        // R9 unmapped write
    '{1'b0, 1'b1, 2'd2, 10'h3F0, 32'h0,        1'b0, 32'h0},        // R9
    '{1'b0, 1'b1, 2'd2, 10'h308, 32'h0,        1'b0, 32'h0},        // R9
    '{1'b0, 1'b0, 2'd2, 10'h000, 32'h0,        1'b1, 32'h0},        // R8 user read
    '{1'b1, 1'b0, 2'd2, 10'h100, 32'h00000001, 1'b1, 32'h0},        // R8 user set, gate off
    '{1'b0, 1'b1, 2'd2, 10'h100, 32'h0,        1'b0, 32'h0},        // R8 no effect
    '{1'b1, 1'b1, 2'd2, 10'h300, 32'h00000001, 1'b0, 32'h0},        // R7 open gate
    '{1'b0, 1'b1, 2'd2, 10'h300, 32'h0,        1'b0, 32'h00000001}, // R7
    '{1'b1, 1'b0, 2'd2, 10'h100, 32'h00000003, 1'b0, 32'h0},        // R7 user set
    '{1'b0, 1'b1, 2'd2, 10'h100, 32'h0,        1'b0, 32'h00000003}, // R3
    '{1'b1, 1'b0, 2'd2, 10'h180, 32'h00000001, 1'b1, 32'h0},        // R8 user clear
    '{1'b1, 1'b0, 2'd2, 10'h000, 32'h000000FF, 1'b1, 32'h0},        // R8 user enable
    '{1'b0, 1'b1, 2'd2, 10'h000, 32'h0,        1'b0, 32'h00000084}, // R8 enable unchanged
    '{1'b0, 1'b1, 2'd2, 10'h100, 32'h0,        1'b0, 32'h00000003}, // R8 pending unchanged
    '{1'b1, 1'b1, 2'd2, 10'h180, 32'h00000001, 1'b0, 32'h0},        // R3 clear
    '{1'b0, 1'b1, 2'd2, 10'h180, 32'h0,        1'b0, 32'h00000002}, // R3
    '{1'b0, 1'b0, 2'd2, 10'h300, 32'h0,        1'b1, 32'h0},        // R8 user ctrl read
    '{1'b1, 1'b0, 2'd2, 10'h3F0, 32'h0,        1'b1, 32'h0},        // R8 user unmapped
    '{1'b1, 1'b1, 2'd2, 10'h104, 32'hFFFFFFFF, 1'b0, 32'h0},        // R3 word 1
    '{1'b0, 1'b1, 2'd2, 10'h184, 32'h0,        1'b0, 32'h0000FFFF}, // R3
    '{1'b1, 1'b1, 2'd2, 10'h184, 32'hFFFFFFFF, 1'b0, 32'h0}         // R3
  };

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_op(input logic wr, input logic pv, input logic [1:0] sz,
                        input logic [9:0] a, input logic [31:0] d,
                        output logic [31:0] rd, output logic er);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = wr; bus_priv = pv;
    bus_size = sz; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0; bus_priv = 1'b0;
    bus_addr = '0; bus_size = '0; bus_wdata = '0;
    rd = bus_rdata; er = bus_err;
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    finish_run();
  end

  initial begin
    logic [31:0] rd;
    logic        er;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state at the ports
    chk("R1 enable", 64'(irq_enable), 64'h0);
    chk("R1 pending", 64'(irq_pending), 64'h0);
    chk("R1 prio", 64'(irq_prio[63:0]), 64'h0);
    chk("R1 vec_base", 64'(vec_base), 64'h0);
    chk("R1 err", 64'(bus_err), 64'h0);

    for (int v = 0; v < NV; v++) begin
      bus_op(VT[v].wr, VT[v].priv, VT[v].size, VT[v].addr, VT[v].wdata, rd, er);
      chk($sformatf("R8/R11 err vec %0d", v), 64'(er), 64'(VT[v].err));
      chk($sformatf("table rdata vec %0d", v), 64'(rd), 64'(VT[v].rdata));
    end

    // R11 idle response
    @(negedge clk);
    chk("R11 idle rdata", 64'(bus_rdata), 64'h0);
    chk("R11 idle err", 64'(bus_err), 64'h0);

    // R2 R4 R6 exported vectors
    chk("R2 irq_enable", 64'(irq_enable), 64'h0000_8001_0000_0084);
    chk("R4 irq_prio lines 0-3", 64'(irq_prio[15:0]), 64'h1F57);
    chk("R4 irq_prio lines 44-47", 64'(irq_prio[191:176]), 64'hFFFF);
    chk("R6 vec_base", 64'(vec_base), 64'h3FFFFF00);
    chk("R3 irq_pending", 64'(irq_pending), 64'h2);

    // R10 arbiter set and clear on different bits
    @(negedge clk);
    arb_set_pend = N'(1) << 10; arb_clr_pend = N'(1) << 1;
    @(negedge clk);
    arb_set_pend = '0; arb_clr_pend = '0;
    chk("R10 arb set/clear", 64'(irq_pending), 64'h400);

    // R10 set wins on the same bit
    @(negedge clk);
    arb_set_pend = N'(1) << 5; arb_clr_pend = N'(1) << 5;
    @(negedge clk);
    arb_set_pend = '0; arb_clr_pend = '0;
    chk("R10 set wins", 64'(irq_pending), 64'h420);

    // R10 bus set with arbiter clear in the same cycle
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b1; bus_priv = 1'b1;
    bus_size = 2'd2; bus_addr = 10'h100; bus_wdata = 32'h400;
    arb_clr_pend = N'(1) << 10;
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0; bus_priv = 1'b0;
    bus_addr = '0; bus_wdata = '0; arb_clr_pend = '0;
    chk("R10 bus set vs arb clear", 64'(irq_pending), 64'h420);

    // R1 reset in mid-run
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    chk("R1 enable after reset", 64'(irq_enable), 64'h0);
    chk("R1 pending after reset", 64'(irq_pending), 64'h0);
    chk("R1 prio after reset", 64'(irq_prio[191:128]), 64'h0);
    bus_op(1'b0, 1'b1, 2'd2, 10'h304, 32'h0, rd, er);
    chk("R1 vec_base read", 64'(rd), 64'h0);
    bus_op(1'b0, 1'b1, 2'd2, 10'h300, 32'h0, rd, er);
    chk("R1 ctrl read", 64'(rd), 64'h0);
    bus_op(1'b1, 1'b0, 2'd2, 10'h100, 32'h1, rd, er);
    chk("R8 user set after reset err", 64'(er), 64'h1);
    chk("R8 user set after reset pending", 64'(irq_pending), 64'h0);

    finish_run();
  end

endmodule